// File: doc/BRIEF.md
# Serial Port Register Block with Prioritized Interrupt

This block is the byte-wide register side of a classic asynchronous serial port. It sits behind a small read/write bus with eight addresses. Through that bus it exposes the receive/transmit data port, the interrupt enable and identification registers, queue control, line and modem control, line and modem status, a scratch byte and a sixteen-bit baud divisor. The divisor shares addresses 0 and 1 with the data port and the enable register, and a select bit in the line control register chooses between them. The block does no serial shifting and no baud timing. A written data byte leaves on a one-cycle transmit strobe. Received bytes arrive on a push port and wait in a receive queue. The queue holds one byte in legacy mode and DEPTH bytes once queue mode is enabled.

After every cycle the block works out a single interrupt cause from its state. The causes, highest priority first, are a receive overrun, data waiting, a sticky transmit-empty flag, and a change on the modem lines. Each cause counts only when its enable is set. The identification register reports the cause, and the interrupt output is high whenever a cause exists. A loopback mode routes written bytes back into the receive queue and derives the modem inputs from the modem control outputs.

Top module: `sio_regblock`

## Requirements
- R1: After reset the divisor reads 12 (low byte) and 0 (high byte), line status reads 0x60, identification reads 0x01, modem status reads 0xA0, and the interrupt output, transmit strobe and read data are low.
- R2: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte; neither access touches the data port or the enable register.
- R3: Identification bits 3:0 report the cause. Overrun with enable bit 2 gives 0x6, queued data with enable bit 0 gives 0x4, a pending transmit-empty flag with enable bit 1 gives 0x2, and a modem delta with enable bit 3 gives 0x0. When several apply, the one listed first wins, and 0x1 means no cause. The interrupt output is high exactly when the cause is not 0x1.
- R4: The transmit-empty flag is set by a data-port write and by a write that takes enable bit 1 from 0 to 1. A read of the identification register while it reports 0x2 clears the flag.
- R5: The enable register keeps only written bits 3:0 and the modem control register only bits 4:0; the other bits read as zero.
- R6: A write at offset 2 whose bit 0 differs from the current queue mode empties the receive queue. It also sets the capacity to DEPTH (bit 0 = 1) or to one byte (bit 0 = 0).
- R7: A write at offset 2 with bit 0 clear changes nothing beyond R6. With bit 0 set, bit 1 empties the receive queue.
- R8: Identification bits 7:6 read 11 while queue mode is on and 00 otherwise.
- R9: Line status reads bit 6 = 1, bit 5 = 1, bit 1 = overrun and bit 0 = queue not empty, with all other bits 0. Reading it clears the overrun bit.
- R10: A byte pushed into a full receive queue is discarded and sets the overrun bit.
- R11: A data-port write outside loopback raises the transmit strobe for one cycle with the written byte. A data-port read returns and removes the oldest queued byte, or 0xFF when the queue is empty.
- R12: With modem control bit 4 set, data-port writes go into the receive queue without a strobe and the receive push port is ignored. Modem status bits 4, 5, 6 and 7 then follow control bits 1, 0, 2 and 3. Outside loopback, status bits 7:4 read 1010.
- R13: A modem control write that changes status bit 4, 5 or 7 sets delta bit 0, 1 or 3. A change of bit 6 from 1 to 0 sets delta bit 2. Reading modem status returns the deltas in bits 3:0 and then clears them.
- R14: Writes at offsets 5 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| rx_push | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Received byte |
| tx_stb | output | 1 | One-cycle strobe for a transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt, high while a cause exists |

## Verification
The assertions take for granted that each bus access lasts one cycle and that read data is used only in the cycle after the read. They also assume nothing but the written bytes reaches the divisor, loopback and queue-mode bits. The stimulus drives one bus access or one receive push per cycle and never both, so pops, flushes and pushes never collide. It biases line control writes to keep the divisor select mostly clear and toggles loopback often, so every interrupt source and both queue capacities are reached.

// File: rtl/sio_regblock_pkg.sv
package sio_regblock_pkg;

    typedef enum logic [3:0] {
        CAUSE_MODEM = 4'h0,
        CAUSE_NONE  = 4'h1,
        CAUSE_THRE  = 4'h2,
        CAUSE_RXD   = 4'h4,
        CAUSE_LINE  = 4'h6
    } cause_e;

    localparam logic [2:0] ADR_DATA  = 3'd0;
    localparam logic [2:0] ADR_IEN   = 3'd1;
    localparam logic [2:0] ADR_IDENT = 3'd2;
    localparam logic [2:0] ADR_LCTL  = 3'd3;
    localparam logic [2:0] ADR_MCTL  = 3'd4;
    localparam logic [2:0] ADR_LSTAT = 3'd5;
    localparam logic [2:0] ADR_MSTAT = 3'd6;
    localparam logic [2:0] ADR_SCR   = 3'd7;

    // Modem input nibble {dcd, ri, dsr, cts} seen for a given control value.
    function automatic logic [3:0] modem_lines(input logic [4:0] mctl);
        if (mctl[4]) return {mctl[3], mctl[2], mctl[0], mctl[1]};
        return 4'b1010;
    endfunction

endpackage

// File: rtl/sio_rxq.sv
module sio_rxq #(
    parameter int DEPTH = 16,
    parameter int BW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              deep,
    input  logic              push,
    input  logic [BW-1:0]     push_byte,
    input  logic              pop,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [BW-1:0]     head,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t s_d, s_q;
    logic [BW-1:0] mem [DEPTH];
    logic accept, take;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = s_q.cnt >= (deep ? CW'(DEPTH) : CW'(1));
    assign count = s_q.cnt;
    assign head  = mem[s_q.rd];

    always_comb begin
        s_d    = s_q;
        accept = push && !full && !flush;
        take   = pop && (s_q.cnt != '0) && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (accept) s_d.wr = bump(s_q.wr);
            if (take)   s_d.rd = bump(s_q.rd);
            s_d.cnt = s_q.cnt + CW'(accept) - CW'(take);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[s_q.wr] <= push_byte;
    end

endmodule

// File: rtl/sio_irq_sel.sv
module sio_irq_sel
    import sio_regblock_pkg::*;
(
    input  logic       overrun,
    input  logic       rx_ready,
    input  logic       thre_pend,
    input  logic       mdelta_any,
    input  logic [3:0] ien,
    output cause_e     cause
);
    always_comb begin
        if (overrun && ien[2])         cause = CAUSE_LINE;
        else if (rx_ready && ien[0])   cause = CAUSE_RXD;
        else if (thre_pend && ien[1])  cause = CAUSE_THRE;
        else if (mdelta_any && ien[3]) cause = CAUSE_MODEM;
        else                           cause = CAUSE_NONE;
    end
endmodule

// File: rtl/sio_modem_track.sv
module sio_modem_track
    import sio_regblock_pkg::*;
(
    input  logic [4:0] mctl_new,
    input  logic [3:0] lines_old,
    output logic [3:0] lines_new,
    output logic [3:0] delta_new
);
    always_comb begin
        lines_new    = modem_lines(mctl_new);
        delta_new[0] = lines_new[0] ^ lines_old[0];
        delta_new[1] = lines_new[1] ^ lines_old[1];
        delta_new[2] = lines_old[2] & ~lines_new[2];
        delta_new[3] = lines_new[3] ^ lines_old[3];
    end
endmodule

// File: rtl/sio_regblock.sv
module sio_regblock
    import sio_regblock_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int REF_HZ = 1843200,
    parameter int BAUD   = 9600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    output logic       tx_stb,
    output logic [7:0] tx_byte,
    output logic       irq
);
    localparam int          DIV   = REF_HZ / BAUD / 16;
    localparam logic [15:0] DIV16 = DIV[15:0];
    localparam int          CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [7:0] dll;
        logic [7:0] dlh;
        logic [7:0] lcr;
        logic [7:0] scr;
        logic [3:0] ien;
        logic [4:0] mctl;
        logic       fen;
        logic       oe;
        logic       thre;
        logic [3:0] lines;
        logic [3:0] mdelta;
        logic [7:0] rdata;
        logic       tx_stb;
        logic [7:0] tx_byte;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        dll: DIV16[7:0], dlh: DIV16[15:8], lcr: '0, scr: '0, ien: '0,
        mctl: '0, fen: 1'b0, oe: 1'b0, thre: 1'b0,
        lines: modem_lines(5'd0), mdelta: '0, rdata: '0,
        tx_stb: 1'b0, tx_byte: '0
    };

    regs_t r_d, r_q;

    logic          q_flush, q_push, q_pop, q_full;
    logic [7:0]    q_pbyte, q_head;
    logic [CW-1:0] q_count;
    logic [3:0]    mt_lines, mt_delta;
    cause_e        cause;
    logic          dlab, loop;

    assign dlab = r_q.lcr[7];
    assign loop = r_q.mctl[4];

    sio_rxq #(.DEPTH(DEPTH), .BW(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(q_flush), .deep(r_q.fen),
        .push(q_push), .push_byte(q_pbyte), .pop(q_pop),
        .count(q_count), .head(q_head), .full(q_full)
    );

    sio_irq_sel u_irq (
        .overrun(r_q.oe), .rx_ready(q_count != '0), .thre_pend(r_q.thre),
        .mdelta_any(|r_q.mdelta), .ien(r_q.ien), .cause(cause)
    );

    sio_modem_track u_modem (
        .mctl_new(bus_wdata[4:0]), .lines_old(r_q.lines),
        .lines_new(mt_lines), .delta_new(mt_delta)
    );

    always_comb begin
        r_d        = r_q;
        r_d.tx_stb = 1'b0;
        q_flush    = 1'b0;
        q_pop      = 1'b0;
        q_push     = rx_push && !loop;
        q_pbyte    = rx_byte;

        if (bus_sel && bus_wr) begin
            case (bus_addr)
                ADR_DATA: begin
                    if (dlab) begin
                        r_d.dll = bus_wdata;
                    end else begin
                        r_d.thre = 1'b1;
                        if (loop) begin
                            q_push  = 1'b1;
                            q_pbyte = bus_wdata;
                        end else begin
                            r_d.tx_stb  = 1'b1;
                            r_d.tx_byte = bus_wdata;
                        end
                    end
                end
                ADR_IEN: begin
                    if (dlab) begin
                        r_d.dlh = bus_wdata;
                    end else begin
                        if (!r_q.ien[1] && bus_wdata[1]) r_d.thre = 1'b1;
                        r_d.ien = bus_wdata[3:0];
                    end
                end
                ADR_IDENT: begin
                    if (bus_wdata[0] != r_q.fen)      q_flush = 1'b1;
                    if (bus_wdata[0] && bus_wdata[1]) q_flush = 1'b1;
                    r_d.fen = bus_wdata[0];
                end
                ADR_LCTL: r_d.lcr = bus_wdata;
                ADR_MCTL: begin
                    r_d.mctl   = bus_wdata[4:0];
                    r_d.lines  = mt_lines;
                    r_d.mdelta = r_q.mdelta | mt_delta;
                end
                ADR_SCR:  r_d.scr = bus_wdata;
                default: ;
            endcase
        end else if (bus_sel) begin
            case (bus_addr)
                ADR_DATA: begin
                    if (dlab) begin
                        r_d.rdata = r_q.dll;
                    end else begin
                        r_d.rdata = (q_count != '0) ? q_head : 8'hFF;
                        q_pop     = 1'b1;
                    end
                end
                ADR_IEN:   r_d.rdata = dlab ? r_q.dlh : {4'h0, r_q.ien};
                ADR_IDENT: begin
                    r_d.rdata = {r_q.fen, r_q.fen, 2'b00, cause};
                    if (cause == CAUSE_THRE) r_d.thre = 1'b0;
                end
                ADR_LCTL:  r_d.rdata = r_q.lcr;
                ADR_MCTL:  r_d.rdata = {3'b000, r_q.mctl};
                ADR_LSTAT: begin
                    r_d.rdata = {1'b0, 2'b11, 3'b000, r_q.oe, q_count != '0};
                    r_d.oe    = 1'b0;
                end
                ADR_MSTAT: begin
                    r_d.rdata  = {r_q.lines, r_q.mdelta};
                    r_d.mdelta = '0;
                end
                default:   r_d.rdata = r_q.scr;
            endcase
        end

        if (q_push && q_full && !q_flush) r_d.oe = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign tx_stb    = r_q.tx_stb;
    assign tx_byte   = r_q.tx_byte;
    assign irq       = (cause != CAUSE_NONE);

endmodule

// File: rtl/sio_regblock_chk.sv
module sio_regblock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       tx_stb,
    input logic [7:0] tx_byte,
    input logic       irq,
    input logic [3:0] ien,
    input logic       dlab,
    input logic       loop,
    input logic       fen
);
    a_r11_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd0 && !dlab && !loop)
        |=> (tx_stb && tx_byte == $past(bus_wdata)));

    a_r11_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> $past(bus_sel && bus_wr && bus_addr == 3'd0));

    a_r5_ien_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd1 && !dlab) |=> (bus_rdata[7:4] == 4'h0));

    a_r9_lstat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd5) |=> (bus_rdata[6:5] == 2'b11 && !bus_rdata[7]));

    a_r8_ident_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd2 && fen) |=> (bus_rdata[7:6] == 2'b11));

    a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 4'h0) |-> !irq);
endmodule

bind sio_regblock sio_regblock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .irq(irq), .ien(r_q.ien),
    .dlab(r_q.lcr[7]), .loop(r_q.mctl[4]), .fen(r_q.fen)
);

// File: tb/sio_regblock_bench.sv
module sio_regblock_bench;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, rx_push = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, rx_byte = '0;
    logic [7:0] bus_rdata, tx_byte;
    logic tx_stb, irq;

    always #4 clk = ~clk;

    sio_regblock #(.DEPTH(DEPTH)) u_sio_regblock (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_stb(tx_stb),
        .tx_byte(tx_byte), .irq(irq)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    // reference state
    logic [7:0] m_dll = 8'd12, m_dlh = 8'd0, m_lcr = 0, m_scr = 0;
    logic [3:0] m_ien = 0, m_lines = 4'b1010, m_del = 0;
    logic [4:0] m_mctl = 0;
    logic m_fen = 0, m_oe = 0, m_thre = 0;
    logic [7:0] mq[$];
    logic exp_tx;
    logic [7:0] exp_txb;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_lines_of(logic [4:0] mc);
        if (!mc[4]) return 4'b1010;
        return {mc[3], mc[2], mc[0], mc[1]};
    endfunction

    function automatic logic [3:0] m_cause();
        if (m_oe && m_ien[2]) return 4'h6;
        if (mq.size() > 0 && m_ien[0]) return 4'h4;
        if (m_thre && m_ien[1]) return 4'h2;
        if (m_del != 0 && m_ien[3]) return 4'h0;
        return 4'h1;
    endfunction

    task automatic m_push(logic [7:0] b);
        int cap = m_fen ? DEPTH : 1;
        if (mq.size() < cap) mq.push_back(b);
        else m_oe = 1'b1;
    endtask

    task automatic m_write(logic [2:0] a, logic [7:0] v);
        logic [3:0] nl;
        case (a)
            0: if (m_lcr[7]) m_dll = v;
               else begin
                   m_thre = 1'b1;
                   if (m_mctl[4]) m_push(v);
                   else begin exp_tx = 1'b1; exp_txb = v; end
               end
            1: if (m_lcr[7]) m_dlh = v;
               else begin
                   if (!m_ien[1] && v[1]) m_thre = 1'b1;
                   m_ien = v[3:0];
               end
            2: begin
                   if (v[0] != m_fen || (v[0] && v[1])) mq.delete();
                   m_fen = v[0];
               end
            3: m_lcr = v;
            4: begin
                   m_mctl = v[4:0];
                   nl = m_lines_of(m_mctl);
                   if (nl[0] != m_lines[0]) m_del[0] = 1'b1;
                   if (nl[1] != m_lines[1]) m_del[1] = 1'b1;
                   if (m_lines[2] && !nl[2]) m_del[2] = 1'b1;
                   if (nl[3] != m_lines[3]) m_del[3] = 1'b1;
                   m_lines = nl;
               end
            7: m_scr = v;
            default: ;
        endcase
    endtask

    task automatic m_read(logic [2:0] a, output logic [7:0] r);
        logic [3:0] c;
        case (a)
            0: if (m_lcr[7]) r = m_dll;
               else if (mq.size() > 0) r = mq.pop_front();
               else r = 8'hFF;
            1: r = m_lcr[7] ? m_dlh : {4'h0, m_ien};
            2: begin
                   c = m_cause();
                   if (c == 4'h2) m_thre = 1'b0;
                   r = {m_fen, m_fen, 2'b00, c};
               end
            3: r = m_lcr;
            4: r = {3'b000, m_mctl};
            5: begin r = {1'b0, 2'b11, 3'b000, m_oe, mq.size() > 0}; m_oe = 1'b0; end
            6: begin r = {m_lines, m_del}; m_del = 0; end
            default: r = m_scr;
        endcase
    endtask

    // one cycle: either a bus access or a receive push
    task automatic op(bit is_push, bit wr, logic [2:0] a, logic [7:0] d, string tag);
        logic [7:0] er = 0;
        bit do_rd = 0;
        exp_tx = 1'b0;
        if (is_push) begin
            if (!m_mctl[4]) m_push(d);
            rx_push = 1'b1; rx_byte = d;
        end else begin
            if (wr) m_write(a, d);
            else begin m_read(a, er); do_rd = 1; end
            bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        end
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; rx_push = 1'b0;
        if (do_rd) check(tag, bus_rdata, er);
        check("R11 strobe", {7'b0, tx_stb}, {7'b0, exp_tx});
        if (exp_tx) check("R11 byte", tx_byte, exp_txb);
        check("R3/R13 irq", {7'b0, irq}, {7'b0, m_cause() != 4'h1});
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, string tag); op(0, 1, a, d, tag); endtask
    task automatic rd(logic [2:0] a, string tag); op(0, 0, a, 8'h00, tag); endtask
    task automatic psh(logic [7:0] b, string tag); op(1, 0, 3'd0, b, tag); endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 strobe", {7'b0, tx_stb}, 8'h00);
        rd(5, "R1"); rd(2, "R1"); rd(6, "R1");
        // R2 divisor window
        wr(3, 8'h80, "R2"); rd(0, "R2"); rd(1, "R2");
        wr(0, 8'h34, "R2"); wr(1, 8'h12, "R2"); rd(0, "R2"); rd(1, "R2");
        wr(3, 8'h03, "R2"); rd(1, "R2"); rd(3, "R2");
        // R5 masks
        wr(1, 8'hFF, "R5"); rd(1, "R5"); wr(4, 8'hEF, "R5"); rd(4, "R5"); wr(4, 8'h00, "R5");
        // R4 transmit-empty flag
        rd(2, "R4"); rd(2, "R4");
        wr(0, 8'h55, "R4"); rd(2, "R4"); rd(2, "R4");
        wr(1, 8'h0D, "R4"); wr(1, 8'h0F, "R4"); rd(2, "R4");
        // R3, R9, R10, R11 in legacy mode
        psh(8'hA1, "R3"); rd(2, "R3"); psh(8'hA2, "R10"); rd(2, "R3");
        rd(5, "R9"); rd(5, "R9"); rd(0, "R11"); rd(0, "R10"); rd(0, "R11");
        // R6 and R8 queue mode
        wr(2, 8'h01, "R6"); rd(2, "R8");
        for (int i = 0; i < DEPTH + 4; i++) psh(8'h10 + 8'(i), "R6");
        rd(5, "R10");
        for (int i = 0; i < DEPTH + 1; i++) rd(0, "R6");
        psh(8'h3C, "R6"); wr(2, 8'h00, "R6"); rd(5, "R6"); rd(2, "R8");
        // R7
        psh(8'h5A, "R7"); wr(2, 8'h02, "R7"); rd(0, "R7");
        wr(2, 8'h01, "R7"); psh(8'h61, "R7"); psh(8'h62, "R7");
        wr(2, 8'h03, "R7"); rd(5, "R7"); rd(0, "R7");
        // R12 and R13 loopback and modem deltas
        wr(4, 8'h10, "R12"); rd(6, "R13"); wr(0, 8'h77, "R12");
        psh(8'h99, "R12"); rd(0, "R12"); rd(0, "R12");
        wr(4, 8'h1F, "R12"); rd(2, "R13"); rd(6, "R13"); rd(6, "R13");
        wr(4, 8'h1B, "R13"); rd(6, "R13"); wr(4, 8'h00, "R13"); rd(6, "R13");
        // R14 ignored writes
        psh(8'h42, "R14"); wr(5, 8'h00, "R14"); wr(6, 8'hFF, "R14");
        rd(5, "R14"); rd(6, "R14"); rd(0, "R14");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 10;
            logic [2:0] a = 3'($urandom);
            logic [7:0] d = 8'($urandom);
            if (r < 3) psh(d, "R10");
            else begin
                if (a == 3'd3 && ($urandom % 4) != 0) d[7] = 1'b0;
                if (a == 3'd2 && ($urandom % 3) != 0) d[1] = 1'b0;
                op(0, r < 6, a, d, "R11 random read");
            end
        end
        summary();
    end
endmodule